// File: doc/BRIEF.md
# Configuration Register Long-Form Access Engine

This block serves the long-form configuration access instruction of a multi-function model-railway decoder. Packet framing and error checking have already run upstream. For each accepted three-byte instruction addressed to this decoder, the front end raises a one-cycle strobe. It also reports whether the packet arrived on the consist address. A separate one-cycle notification marks every other valid packet addressed to the decoder, broadcasts included.

The engine holds a small file of eight-bit configuration registers, numbered from 1. It carries out four operations on them: byte verify, byte write, bit verify and bit write. A verify compares against the stored value and answers with a one-cycle match pulse. A write is only armed by its first packet. The register changes when the exact same write packet arrives a second time with no other packet to the decoder in between. The commit is signalled by a one-cycle acknowledge pulse. The non-volatile store is modelled as plain registers. The physical acknowledge signalling is left to a neighbouring block.

Top module: `cv_long_access`

## Requirements
- R1: An instruction is well formed only if the top nibble of the first byte is 1110, the type field (first byte bits 3:2) is not 00, and, for type 10, the third byte bits 7:5 are 111. A malformed instruction gives no pulse and changes no register, but it still counts as a packet that cancels a pending write.
- R2: The 10-bit address is formed from the first byte bits 1:0 (most significant) and the whole second byte. Address value n selects register n+1, so address 0 selects register 1.
- R3: Type 01 (byte verify) raises `verify_ok` for exactly one cycle, in the cycle after the strobe, if and only if the selected register equals the third byte.
- R4: Type 10 with a third byte 111CDAAA and C=0 (bit verify) raises `verify_ok` one cycle after the strobe if and only if bit AAA of the register equals D.
- R5: Type 11 (byte write) changes nothing on its first packet. A second identical packet, with any number of idle cycles between the two, loads the third byte into the register and raises `write_ack` for one cycle after that strobe.
- R6: Type 10 with C=1 (bit write) on its second identical packet sets bit AAA of the register to D and leaves the other seven bits unchanged, with `write_ack` as in R5.
- R7: A pending write is cancelled by an `other_pkt` notification, or by any long-form instruction that is not a write, before its repeat arrives.
- R8: A write whose bytes differ from the pending one replaces it, so only a repeat of the newest write commits.
- R9: A commit consumes the pending write. A third identical packet arms the write again and does not acknowledge.
- R10: An instruction strobed with `on_consist` high is ignored entirely: no pulse, no register change, and the pending write is kept.
- R11: An address at or beyond the register count gives no verify match, never commits, and cancels a pending write.
- R12: After reset every register reads 0, no write is pending, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | One-cycle strobe for a long-form instruction to this decoder |
| on_consist | input | 1 | Qualifies the strobe: the packet came on the consist address |
| other_pkt | input | 1 | One-cycle notice of any other valid packet to this decoder |
| instr_b0 | input | 8 | First instruction byte (opcode, type, address high bits) |
| instr_b1 | input | 8 | Second instruction byte (address low bits) |
| instr_b2 | input | 8 | Third instruction byte (data, or bit-manipulation field) |
| verify_ok | output | 1 | One-cycle pulse: verify matched |
| write_ack | output | 1 | One-cycle pulse: write committed |

## Verification
Every register is written with an address-dependent value through a pair of packets separated by idle cycles. Each is then verified with the correct byte and with a one-bit-off byte, which tells the address mapping apart from a comparison that always matches. A full sweep of bit verifies over every register, bit position and bit value checks that the bit selection is right. Ordered sequences then separate the pending-write rules: cancellation by a foreign packet or by a verify, replacement by a different write, consumption on commit, survival across a consist packet, and cancellation by an out-of-range or malformed instruction.

// File: rtl/cvla_pkg.sv
package cvla_pkg;
  localparam int CV_ADDR_W = 10;
  localparam int TUPLE_W   = 20;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_VFY_BYTE,
    OP_WR_BYTE,
    OP_VFY_BIT,
    OP_WR_BIT
  } cv_op_e;

  typedef struct packed {
    cv_op_e                op;
    logic [CV_ADDR_W-1:0]  addr;
    logic [7:0]            data;
    logic [2:0]            bsel;
    logic                  bval;
  } cv_instr_s;
endpackage

// File: rtl/cvla_decode.sv
module cvla_decode
  import cvla_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic [7:0] b0,
  input  logic [7:0] b1,
  input  logic [7:0] b2,
  output cv_instr_s  dec,
  output logic       in_range
);
  always_comb begin
    dec      = '0;
    dec.addr = {b0[1:0], b1};
    dec.data = b2;
    dec.bsel = b2[2:0];
    dec.bval = b2[3];
    dec.op   = OP_NONE;
    if (b0[7:4] == 4'b1110) begin
      unique case (b0[3:2])
        2'b01:   dec.op = OP_VFY_BYTE;
        2'b11:   dec.op = OP_WR_BYTE;
        2'b10: begin
          if (b2[7:5] == 3'b111) dec.op = b2[4] ? OP_WR_BIT : OP_VFY_BIT;
        end
        default: dec.op = OP_NONE;
      endcase
    end
  end

  assign in_range = (32'(dec.addr) < NUM_REGS);
endmodule

// File: rtl/cvla_pending.sv
module cvla_pending
  import cvla_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_seen,
  input  logic               other_pkt,
  input  logic               is_write,
  input  logic [TUPLE_W-1:0] tuple,
  output logic               commit,
  output logic               pend_valid
);
  logic               pv_q, pv_d;
  logic [TUPLE_W-1:0] pt_q, pt_d;
  logic               pt_en;

  always_comb begin
    pv_d   = pv_q;
    pt_d   = pt_q;
    pt_en  = 1'b0;
    commit = 1'b0;
    if (other_pkt) pv_d = 1'b0;
    if (instr_seen) begin
      if (is_write) begin
        if (pv_q && !other_pkt && (pt_q == tuple)) begin
          commit = 1'b1;
          pv_d   = 1'b0;
        end else begin
          pv_d  = 1'b1;
          pt_d  = tuple;
          pt_en = 1'b1;
        end
      end else begin
        pv_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= pv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pt_q <= '0;
    else if (pt_en) pt_q <= pt_d;
  end

  assign pend_valid = pv_q;

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (other_pkt && !instr_seen) |=> !pend_valid);
endmodule

// File: rtl/cvla_regfile.sv
module cvla_regfile #(
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic [2:0]       wr_bsel,
  input  logic             wr_bval,
  input  logic [7:0]       wr_data
);
  logic [7:0]            mem_q [NUM_REGS];
  logic [7:0]            wr_cur, wr_word;
  logic [NUM_REGS*8-1:0] mem_flat;

  generate
    if ((1 << IDX_W) == NUM_REGS) begin : g_pow2
      assign rd_data = mem_q[rd_idx];
      assign wr_cur  = mem_q[wr_idx];
    end else begin : g_guard
      assign rd_data = (32'(rd_idx) < NUM_REGS) ? mem_q[rd_idx] : 8'h00;
      assign wr_cur  = (32'(wr_idx) < NUM_REGS) ? mem_q[wr_idx] : 8'h00;
    end
  endgenerate

  always_comb begin
    wr_word = wr_data;
    if (wr_bit) begin
      wr_word          = wr_cur;
      wr_word[wr_bsel] = wr_bval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= 8'h00;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (32'(wr_idx) == i) mem_q[i] <= wr_word;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
      assign mem_flat[g*8 +: 8] = mem_q[g];
    end
  endgenerate

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(mem_flat));
endmodule

// File: rtl/cv_long_access.sv
module cv_long_access
  import cvla_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_valid,
  input  logic       on_consist,
  input  logic       other_pkt,
  input  logic [7:0] instr_b0,
  input  logic [7:0] instr_b1,
  input  logic [7:0] instr_b2,
  output logic       verify_ok,
  output logic       write_ack
);
  cv_instr_s          dec;
  logic               in_range, seen, is_write, commit, pend_valid;
  logic [IDX_W-1:0]   idx;
  logic [7:0]         rd_data;
  logic               vfy_hit;
  logic               vok_q, vok_d, wack_q, wack_d;

  cvla_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .b0(instr_b0), .b1(instr_b1), .b2(instr_b2),
    .dec(dec), .in_range(in_range)
  );

  assign seen     = instr_valid && !on_consist;
  assign is_write = in_range && (dec.op == OP_WR_BYTE || dec.op == OP_WR_BIT);
  assign idx      = dec.addr[IDX_W-1:0];

  cvla_pending u_pend (
    .clk(clk), .rst_n(rst_n),
    .instr_seen(seen), .other_pkt(other_pkt), .is_write(is_write),
    .tuple({instr_b0[3:0], instr_b1, instr_b2}),
    .commit(commit), .pend_valid(pend_valid)
  );

  cvla_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_data(rd_data),
    .wr_en(commit), .wr_idx(idx),
    .wr_bit(dec.op == OP_WR_BIT), .wr_bsel(dec.bsel),
    .wr_bval(dec.bval), .wr_data(dec.data)
  );

  always_comb begin
    unique case (dec.op)
      OP_VFY_BYTE: vfy_hit = (rd_data == dec.data);
      OP_VFY_BIT:  vfy_hit = (rd_data[dec.bsel] == dec.bval);
      default:     vfy_hit = 1'b0;
    endcase
    vok_d  = seen && in_range && vfy_hit;
    wack_d = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vok_q  <= 1'b0;
      wack_q <= 1'b0;
    end else begin
      vok_q  <= vok_d;
      wack_q <= wack_d;
    end
  end

  assign verify_ok = vok_q;
  assign write_ack = wack_q;

  assert_ack_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    write_ack |-> $past(pend_valid));
  assert_pulse_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(verify_ok && write_ack));
  assert_consist_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(instr_valid && on_consist) |-> (!verify_ok && !write_ack));
  assert_range_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(instr_valid && !in_range) |-> (!verify_ok && !write_ack));
endmodule

// File: tb/tb_cv_long_access.sv
module tb_cv_long_access;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 16;

  logic       clk, rst_n, instr_valid, on_consist, other_pkt;
  logic [7:0] b0, b1, b2;
  logic       verify_ok, write_ack;
  logic       got_v, got_w;
  int         checks, errors;
  logic [7:0] model [NREG];
  bit         done;

  cv_long_access #(.NUM_REGS(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .on_consist(on_consist),
    .other_pkt(other_pkt), .instr_b0(b0), .instr_b1(b1), .instr_b2(b2),
    .verify_ok(verify_ok), .write_ack(write_ack)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] x0, input logic [7:0] x1,
                      input logic [7:0] x2, input logic cons);
    b0 = x0; b1 = x1; b2 = x2; on_consist = cons; instr_valid = 1'b1;
    @(negedge clk);
    got_v = verify_ok; got_w = write_ack;
    instr_valid = 1'b0; on_consist = 1'b0;
  endtask

  task automatic wr_byte(input int a, input logic [7:0] d);
    send(8'hEC | 8'(a >> 8), 8'(a), d, 1'b0);
  endtask
  task automatic vf_byte(input int a, input logic [7:0] d);
    send(8'hE4 | 8'(a >> 8), 8'(a), d, 1'b0);
  endtask
  task automatic bit_op(input int a, input logic wr, input int pos, input logic v);
    send(8'hE8 | 8'(a >> 8), 8'(a), {3'b111, wr, v, 3'(pos)}, 1'b0);
  endtask
  task automatic pulse_other();
    other_pkt = 1'b1;
    @(negedge clk);
    other_pkt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; instr_valid = 1'b0; on_consist = 1'b0; other_pkt = 1'b0;
    b0 = '0; b1 = '0; b2 = '0;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 verify_ok after reset", verify_ok, 1'b0);
    chk("R12 write_ack after reset", write_ack, 1'b0);
    vf_byte(0, 8'h00); chk("R12 reg1 reads zero", got_v, 1'b1);
    wr_byte(9, 8'h11); chk("R12 no pending at reset", got_w, 1'b0);
    pulse_other();

    // R5 / R2 / R3 sweep over all registers
    for (int a = 0; a < NREG; a++) begin
      logic [7:0] v;
      v = 8'(a * 37 + 5);
      wr_byte(a, v); chk("R5 first write no ack", got_w, 1'b0);
      repeat (a % 3) @(negedge clk);
      wr_byte(a, v); chk("R5 second write ack", got_w, 1'b1);
      model[a] = v;
      vf_byte(a, v);        chk("R2 R3 verify match", got_v, 1'b1);
      vf_byte(a, v ^ 8'h10); chk("R3 verify mismatch", got_v, 1'b0);
    end
    // R2: high address bits do not alias to low registers
    vf_byte(256 + 3, model[3]); chk("R2 high bits distinct", got_v, 1'b0);

    // R4 exhaustive bit verify
    for (int a = 0; a < NREG; a++)
      for (int p = 0; p < 8; p++)
        for (int v = 0; v < 2; v++) begin
          bit_op(a, 1'b0, p, v[0]);
          chk("R4 bit verify", got_v, model[a][p] == v[0]);
        end

    // R6 bit write
    bit_op(3, 1'b1, 5, ~model[3][5]); chk("R6 first bit write", got_w, 1'b0);
    bit_op(3, 1'b1, 5, ~model[3][5]); chk("R6 second bit write", got_w, 1'b1);
    model[3][5] = ~model[3][5];
    vf_byte(3, model[3]); chk("R6 other bits kept", got_v, 1'b1);

    // R7 cancellation
    wr_byte(2, 8'h55); pulse_other(); wr_byte(2, 8'h55);
    chk("R7 other_pkt cancels", got_w, 1'b0);
    vf_byte(2, model[2]); chk("R7 register unchanged", got_v, 1'b1);
    wr_byte(2, 8'h66); vf_byte(0, 8'h00); wr_byte(2, 8'h66);
    chk("R7 verify cancels", got_w, 1'b0);
    pulse_other();

    // R8 replacement
    wr_byte(4, 8'hA1); wr_byte(4, 8'hB2); chk("R8 differing write", got_w, 1'b0);
    wr_byte(4, 8'hA1); chk("R8 older write replaced", got_w, 1'b0);
    wr_byte(4, 8'hA1); chk("R8 newest repeat commits", got_w, 1'b1);
    model[4] = 8'hA1;

    // R9 consumption
    wr_byte(5, 8'hC3); wr_byte(5, 8'hC3); chk("R9 commit", got_w, 1'b1);
    wr_byte(5, 8'hC3); chk("R9 third packet no ack", got_w, 1'b0);
    model[5] = 8'hC3;
    pulse_other();

    // R10 consist address ignored
    wr_byte(6, 8'hD4);
    send(8'hEC, 8'd6, 8'hD4, 1'b1); chk("R10 consist write no ack", got_w, 1'b0);
    send(8'hE4, 8'd6, model[6], 1'b1); chk("R10 consist verify no pulse", got_v, 1'b0);
    wr_byte(6, 8'hD4); chk("R10 pending kept", got_w, 1'b1);
    model[6] = 8'hD4;

    // R11 out of range
    vf_byte(NREG, 8'h00); chk("R11 verify beyond depth", got_v, 1'b0);
    vf_byte(1023, 8'h00); chk("R11 verify top address", got_v, 1'b0);
    wr_byte(NREG + 4, 8'h12); wr_byte(NREG + 4, 8'h12);
    chk("R11 no commit beyond depth", got_w, 1'b0);
    wr_byte(7, 8'hE5); wr_byte(20, 8'hE5); wr_byte(7, 8'hE5);
    chk("R11 out-of-range cancels", got_w, 1'b0);
    pulse_other();

    // R1 malformed instructions
    send(8'hE0, 8'd0, model[0], 1'b0); chk("R1 reserved type", got_v, 1'b0);
    send(8'hE8, 8'd0, 8'h00, 1'b0);    chk("R1 bad bit field", got_v, 1'b0);
    send(8'hF4, 8'd0, model[0], 1'b0); chk("R1 wrong opcode", got_v, 1'b0);
    wr_byte(8, 8'h77); send(8'hE0, 8'd8, 8'h77, 1'b0); wr_byte(8, 8'h77);
    chk("R1 malformed cancels", got_w, 1'b0);
    vf_byte(8, model[8]); chk("R1 register unchanged", got_v, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule